// File: doc/BRIEF.md
# Link Status and Heartbeat Indicator

This block generates the status and indicator outputs of a point-to-point serial link modem. A synchroniser reports whether the link is locked, and the line decoder raises a strobe for each symbol that breaks the coding rules. From these the block produces five things:

- an active-low carrier-detect output;
- a receive data output that is held low until the link locks;
- two handshake outputs that are held high until the link locks;
- a sticky coding-error flag;
- a short periodic pulse that drives an indicator LED. The pulse repeats eight times faster when the link is not locked.

A reset pin qualifier sits in front of the logic. It takes a device reset only after the pin has stayed low for a long, programmable number of reference-clock cycles. A shorter low glitch has no effect.

Every cycle count is a parameter. The defaults match a 10 MHz reference: a 61,440-cycle pulse, a 15,360,000-cycle locked period, a divide-by-8 unlocked period and a 100 ms reset qualification. A bench can shrink all of these.

Top module: `link_status_ind`

## Requirements
- R1: `carrier_n` equals the inverse of `lock_in` as sampled on the previous clock edge. It is low only while the registered lock is 1.
- R2: While `carrier_n` is 1, `rx_out` is 0 and `cts_out` and `dsr_out` are 1, whatever the raw inputs are. While `carrier_n` is 0 the three raw inputs pass through unchanged.
- R3: A `code_err` level sampled on an edge where the registered lock is already 1 sets `err_flag` after that edge. A `code_err` level sampled while the registered lock is 0 is ignored.
- R4: Once set, `err_flag` stays 1 for as long as `lock_in` stays 1, whatever `code_err` does.
- R5: `err_flag` clears on the same edge that `carrier_n` rises after `lock_in` is sampled low. An accepted reset also clears it.
- R6: Every pulse on `beat` is high for exactly `PULSE_W` consecutive cycles. No pulse is ever cut short.
- R7: The interval from one rising edge of `beat` to the next is `LOCK_PERIOD` cycles while locked and `LOCK_PERIOD/RATIO` cycles while unlocked.
- R8: When the registered lock changes outside a pulse, a new pulse starts on the next edge. When it changes during a pulse, that pulse completes. In both cases the following rising edges are spaced by the new period.
- R9: A device reset is taken only after `rst_pin_n` has been sampled low on `QUAL_CYCLES` consecutive edges. A shorter low pulse leaves every output and the error flag untouched.
- R10: During reset, `carrier_n` is 1, `rx_out` is 0, `cts_out` and `dsr_out` are 1, `err_flag` is 0 and `beat` is 0. After release the heartbeat starts in its gap, and the first pulse rises `LOCK_PERIOD/RATIO - PULSE_W + 1` sampling points after the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_pin_n | input | 1 | Raw reset pin, active low, qualified by duration |
| lock_in | input | 1 | Lock indication from the synchroniser |
| code_err | input | 1 | Per-symbol code-violation strobe from the decoder |
| rx_raw | input | 1 | Raw received data |
| cts_raw | input | 1 | Raw clear-to-send handshake |
| dsr_raw | input | 1 | Raw data-set-ready handshake |
| carrier_n | output | 1 | Carrier detect, low when locked |
| rx_out | output | 1 | Gated received data |
| cts_out | output | 1 | Gated clear-to-send |
| dsr_out | output | 1 | Gated data-set-ready |
| err_flag | output | 1 | Sticky coding-error flag |
| beat | output | 1 | Heartbeat LED pulse, active high |

## Verification
The heartbeat is measured in four situations:

- free-running in each lock state, which separates the two period lengths;
- right after reset release;
- across a full sweep of lock changes, one at every phase of the old period. This separates a change that restarts the period from one that lets a running pulse finish or lets a natural wrap stand.
- with a width monitor running throughout, so that any truncated pulse is caught.

The gating is tried with all raw input combinations in both lock states. The error flag is driven with violations before lock, on the first locked edge, during a long hold and at loss of lock. Reset pulses of one cycle short of the qualification time and of the full time show whether the qualifier counts consecutive low samples.

// File: rtl/lsi_pkg.sv
package lsi_pkg;

    typedef struct packed {
        logic lock;
        logic err;
    } stat_s;

    function automatic int unsigned beat_period(input bit locked,
                                                input int unsigned lock_period,
                                                input int unsigned ratio);
        return locked ? lock_period : lock_period / ratio;
    endfunction

endpackage

// File: rtl/lsi_por_filter.sv
module lsi_por_filter #(
    parameter int unsigned QUAL_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_pin_n,
    output logic dev_rst
);
    localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] QMAX = CW'(QUAL_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (rst_pin_n)          cnt_d = '0;
        else if (cnt_q == QMAX) cnt_d = QMAX;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;

    assign dev_rst = (cnt_q == QMAX);

    // R9: reset can only be held after a low sample on the pin
    a_r9_low_seen: assert property (@(posedge clk) dev_rst |-> $past(!rst_pin_n));
endmodule

// File: rtl/lsi_status.sv
module lsi_status
    import lsi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lock_in,
    input  logic code_err,
    input  logic rx_raw,
    input  logic cts_raw,
    input  logic dsr_raw,
    output logic lock_q,
    output logic carrier_n,
    output logic rx_out,
    output logic cts_out,
    output logic dsr_out,
    output logic err_flag
);
    stat_s s_d, s_q;

    always_comb begin
        if (rst) begin
            s_d.lock = 1'b0;
            s_d.err  = 1'b0;
        end else begin
            s_d.lock = lock_in;
            s_d.err  = lock_in & (s_q.err | (s_q.lock & code_err));
        end
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign lock_q    = s_q.lock;
    assign carrier_n = ~s_q.lock;
    assign rx_out    = s_q.lock & rx_raw;
    assign cts_out   = ~s_q.lock | cts_raw;
    assign dsr_out   = ~s_q.lock | dsr_raw;
    assign err_flag  = s_q.err;

    // R1: carrier only after lock was sampled
    a_r1_carrier_follows: assert property (@(posedge clk) disable iff (rst)
        !carrier_n |-> $past(lock_in));
    // R2: gated outputs idle while carrier is inactive
    a_r2_idle_gating: assert property (@(posedge clk) disable iff (rst)
        carrier_n |-> (!rx_out && cts_out && dsr_out));
    // R3: an error can only exist while carrier is active
    a_r3_err_needs_lock: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> !carrier_n);
    // R4: flag holds while lock stays
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && lock_in) |=> err_flag);
    // R5: loss of lock clears the flag
    a_r5_clear_on_loss: assert property (@(posedge clk) disable iff (rst)
        !lock_in |=> !err_flag);
endmodule

// File: rtl/lsi_heartbeat.sv
module lsi_heartbeat
    import lsi_pkg::*;
#(
    parameter int unsigned PULSE_W     = 61_440,
    parameter int unsigned LOCK_PERIOD = 15_360_000,
    parameter int unsigned RATIO       = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lock,
    output logic beat
);
    localparam int unsigned UNLOCK_PERIOD = beat_period(1'b0, LOCK_PERIOD, RATIO);
    localparam int unsigned W = $clog2(LOCK_PERIOD);
    localparam logic [W-1:0] LAST_L = W'(LOCK_PERIOD - 1);
    localparam logic [W-1:0] LAST_U = W'(UNLOCK_PERIOD - 1);
    localparam logic [W-1:0] PW     = W'(PULSE_W);

    typedef struct packed {
        logic [W-1:0] ph;
        logic         seen;
    } hb_s;

    hb_s        s_d, s_q;
    logic       in_pulse, chg;
    logic [W-1:0] last;

    always_comb begin
        in_pulse = (s_q.ph < PW);
        chg      = lock ^ s_q.seen;
        last     = lock ? LAST_L : LAST_U;
        s_d.seen = lock;
        if (rst) begin
            s_d.ph   = PW;
            s_d.seen = 1'b0;
        end else if (chg && !in_pulse) begin
            s_d.ph = '0;
        end else if (s_q.ph >= last) begin
            s_d.ph = '0;
        end else begin
            s_d.ph = s_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign beat = in_pulse & ~rst;

    // R8: a lock change outside a pulse restarts the period
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        (chg && !in_pulse) |=> (beat && s_q.ph == '0));
    // R7: unlocked phase never passes the short period
    a_r7_phase_bound: assert property (@(posedge clk) disable iff (rst)
        (!lock && !s_q.seen) |-> (s_q.ph <= LAST_U));

    generate
        if (PULSE_W > 1) begin : g_multi
            // R6: a pulse is never a single cycle
            a_r6_no_runt: assert property (@(posedge clk) disable iff (rst)
                $rose(beat) |=> beat);
        end
    endgenerate
endmodule

// File: rtl/link_status_ind.sv
module link_status_ind #(
    parameter int unsigned QUAL_CYCLES = 1_000_000,
    parameter int unsigned PULSE_W     = 61_440,
    parameter int unsigned LOCK_PERIOD = 15_360_000,
    parameter int unsigned RATIO       = 8
) (
    input  logic clk,
    input  logic rst_pin_n,
    input  logic lock_in,
    input  logic code_err,
    input  logic rx_raw,
    input  logic cts_raw,
    input  logic dsr_raw,
    output logic carrier_n,
    output logic rx_out,
    output logic cts_out,
    output logic dsr_out,
    output logic err_flag,
    output logic beat
);
    logic dev_rst;
    logic lock_q;

    lsi_por_filter #(.QUAL_CYCLES(QUAL_CYCLES)) u_por (
        .clk(clk), .rst_pin_n(rst_pin_n), .dev_rst(dev_rst)
    );

    lsi_status u_stat (
        .clk(clk), .rst(dev_rst), .lock_in(lock_in), .code_err(code_err),
        .rx_raw(rx_raw), .cts_raw(cts_raw), .dsr_raw(dsr_raw),
        .lock_q(lock_q), .carrier_n(carrier_n), .rx_out(rx_out),
        .cts_out(cts_out), .dsr_out(dsr_out), .err_flag(err_flag)
    );

    lsi_heartbeat #(.PULSE_W(PULSE_W), .LOCK_PERIOD(LOCK_PERIOD), .RATIO(RATIO)) u_hb (
        .clk(clk), .rst(dev_rst), .lock(lock_q), .beat(beat)
    );

    // R10: quiet outputs while reset is held
    a_r10_reset_beat: assert property (@(posedge clk) dev_rst |-> !beat);
endmodule

// File: tb/sim_link_status_ind.sv
module sim_link_status_ind;
    localparam int QUAL = 20;
    localparam int PW   = 4;
    localparam int LP   = 128;
    localparam int RT   = 8;
    localparam int UP   = LP / RT;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_pin_n = 1'b1, lock_in = 1'b0, code_err = 1'b0;
    logic rx_raw = 1'b0, cts_raw = 1'b0, dsr_raw = 1'b0;
    logic carrier_n, rx_out, cts_out, dsr_out, err_flag, beat;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    link_status_ind #(.QUAL_CYCLES(QUAL), .PULSE_W(PW), .LOCK_PERIOD(LP), .RATIO(RT)) u0 (
        .clk(clk), .rst_pin_n(rst_pin_n), .lock_in(lock_in), .code_err(code_err),
        .rx_raw(rx_raw), .cts_raw(cts_raw), .dsr_raw(dsr_raw),
        .carrier_n(carrier_n), .rx_out(rx_out), .cts_out(cts_out), .dsr_out(dsr_out),
        .err_flag(err_flag), .beat(beat)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sampling points until beat is seen rising; -1 if none within limit
    task automatic rise_dist(output int d);
        logic prev;
        prev = beat;
        d = -1;
        for (int i = 1; i <= 1000; i++) begin
            @(negedge clk);
            if (beat && !prev) begin d = i; break; end
            prev = beat;
        end
    endtask

    // R6 width monitor
    logic mprev = 1'b1;
    int   run = 0;
    bit   valid = 1'b0;
    always @(negedge clk) begin
        if (!mon_en) begin
            mprev = 1'b1; run = 0; valid = 1'b0;
        end else begin
            if (beat && !mprev) begin valid = 1'b1; run = 1; end
            else if (beat && valid) run++;
            else if (!beat && mprev && valid) chk("R6 pulse width", run, PW);
            mprev = beat;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int d;
        tick(2);
        // reset
        rst_pin_n = 1'b0;
        tick(QUAL + 2);
        chk("R10 carrier_n in reset", carrier_n, 1);
        chk("R10 rx_out in reset", rx_out, 0);
        chk("R10 cts_out in reset", cts_out, 1);
        chk("R10 dsr_out in reset", dsr_out, 1);
        chk("R10 err_flag in reset", err_flag, 0);
        chk("R10 beat in reset", beat, 0);
        rst_pin_n = 1'b1;
        mon_en = 1'b1;
        rise_dist(d);
        chk("R10 first pulse after release", d, UP - PW + 1);

        // R7 unlocked period
        for (int i = 0; i < 3; i++) begin
            rise_dist(d);
            chk("R7 unlocked period", d, UP);
        end

        // R2 gating while unlocked, all raw patterns
        for (int p = 0; p < 8; p++) begin
            {rx_raw, cts_raw, dsr_raw} = 3'(p);
            tick(1);
            chk("R2 rx forced low", rx_out, 0);
            chk("R2 cts forced high", cts_out, 1);
            chk("R2 dsr forced high", dsr_out, 1);
        end

        // R3 violation in the edge lock is first sampled is ignored
        lock_in = 1'b1; code_err = 1'b1;
        #1 chk("R1 carrier before edge", carrier_n, 1);
        tick(1);
        code_err = 1'b0;
        chk("R1 carrier after edge", carrier_n, 0);
        chk("R3 violation before registered lock ignored", err_flag, 0);

        // R2 pass-through while locked
        for (int p = 0; p < 8; p++) begin
            {rx_raw, cts_raw, dsr_raw} = 3'(p);
            #1;
            chk("R2 rx pass", rx_out, (p >> 2) & 1);
            chk("R2 cts pass", cts_out, (p >> 1) & 1);
            chk("R2 dsr pass", dsr_out, p & 1);
            tick(1);
        end

        // R7 locked period
        rise_dist(d);
        for (int i = 0; i < 2; i++) begin
            rise_dist(d);
            chk("R7 locked period", d, LP);
        end

        // R3 set, R4 hold
        code_err = 1'b1;
        tick(1);
        code_err = 1'b0;
        chk("R3 err set", err_flag, 1);
        tick(20);
        chk("R4 err sticky", err_flag, 1);

        // R5 clear at loss of lock, same edge as carrier
        lock_in = 1'b0;
        tick(1);
        chk("R5 err cleared", err_flag, 0);
        chk("R5 carrier raised same edge", carrier_n, 1);
        code_err = 1'b1;
        tick(3);
        code_err = 1'b0;
        chk("R3 violations while unlocked ignored", err_flag, 0);

        // R9 short reset pulse is ignored
        lock_in = 1'b1;
        tick(2);
        code_err = 1'b1; tick(1); code_err = 1'b0;
        chk("R3 err set again", err_flag, 1);
        rst_pin_n = 1'b0;
        tick(QUAL - 1);
        rst_pin_n = 1'b1;
        tick(2);
        chk("R9 short pulse keeps err", err_flag, 1);
        chk("R9 short pulse keeps carrier", carrier_n, 0);
        mon_en = 1'b0;
        rst_pin_n = 1'b0;
        tick(QUAL + 2);
        chk("R9 full pulse clears err", err_flag, 0);
        chk("R9 full pulse drops carrier", carrier_n, 1);
        chk("R10 beat low in reset", beat, 0);
        lock_in = 1'b0;
        rst_pin_n = 1'b1;
        mon_en = 1'b1;

        // R8 sweep: change lock at every phase of the old period
        for (int s = 0; s < 2; s++) begin
            int pold, pnew, exp;
            pold = (s != 0) ? LP : UP;
            pnew = (s != 0) ? UP : LP;
            for (int k = 0; k < pold; k++) begin
                lock_in = (s != 0);
                rise_dist(d);
                rise_dist(d);
                tick(k);
                lock_in = (s == 0);
                if (k <= PW - 2)       exp = pnew - k;
                else if (k == pold - 1) exp = 1;
                else                   exp = 2;
                rise_dist(d);
                chk("R8 first pulse after lock change", d, exp);
                rise_dist(d);
                chk("R8 new period after change", d, pnew);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule